// File: doc/BRIEF.md
# I2C Register-Access Sequencer

This block is a single-master I2C engine. It performs one-byte register writes and one-byte register reads on a slave whose 8-bit device ID is fixed by a parameter. A request carries three things: a read/write flag, a register address and a write byte. The block accepts the request in one cycle and runs the whole bus transaction by itself. When the transaction ends it returns the read byte and a flag that records any missing acknowledge.

A write is sent as a single transaction. A read is sent in two parts. The first part writes the register address and closes with a STOP. The second part opens with a fresh START, uses the ID with its low bit set, takes one byte from the slave and answers it with NACK. Both pins are open-drain: the block only ever pulls a line low or releases it. The bus timing is set in system-clock cycles, through the SCL period and the SDA hold delay.

Top module: `i2c_regseq`

## Requirements
- R1: A write request puts START, then the ID with bit 0 cleared, the register address and the write byte on the bus, then STOP. Each byte is sent MSB first, and each is followed by a slave acknowledge slot in which the master releases SDA.
- R2: A read request puts START, ID (bit 0 clear), register address, then STOP on the bus. It then puts START, the ID with bit 0 set, and one slave-driven byte on the bus. The master answers that byte with NACK (SDA released), then sends STOP. The result is two STARTs and two STOPs.
- R3: After a read, `rdData` holds the byte that the slave drove, MSB first.
- R4: `ackErr` is set when any slave acknowledge slot is sampled high. Once set, it stays set for the rest of that transaction. The transaction still runs to its final STOP. The flag is cleared when the next request is accepted.
- R5: `busy` rises on the cycle after `reqValid` is accepted while the block is idle. `done` pulses high for exactly one cycle. It rises 29·P+H cycles after acceptance for a write and 40·P+2·H cycles after acceptance for a read, where P = SCL_PERIOD and H = SCL_PERIOD/2. `busy` falls on that same cycle. Both lines are released whenever the block is idle.
- R6: Every SCL low phase lasts exactly SCL_PERIOD/2 cycles. Every SCL high phase lasts at least SCL_PERIOD − SCL_PERIOD/2 cycles.
- R7: SDA driven by the master changes while SCL is low only SDA_HOLD cycles after SCL falls. Within a data or acknowledge bit it never changes while SCL is high.
- R8: `reqValid` is ignored while `busy` is high. No extra bytes reach the bus and the running transaction is not altered.
- R9: After reset, `busy`, `done`, `ackErr`, `rdData` and both drive-low outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe, taken only while idle |
| reqRead | input | 1 | 1 = register read, 0 = register write |
| reqAddr | input | 8 | Register address |
| reqData | input | 8 | Byte to write (ignored for reads) |
| sdaIn | input | 1 | Sensed level of the SDA line |
| sclDriveLow | output | 1 | 1 pulls SCL low, 0 releases it |
| sdaDriveLow | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle strobe when the final STOP is complete |
| rdData | output | 8 | Byte captured by the last read |
| ackErr | output | 1 | A slave acknowledge slot was sampled high |

## Verification
The latency of the whole transaction is fixed by the parameters. The bench therefore derives the cycle in which `done` must appear from the START, byte and STOP symbol lengths, and compares that figure with the number of cycles it counts after the accepting edge. It samples `busy` one cycle after acceptance and checks `done` and `busy` again one cycle after the strobe. The read byte, `ackErr` and the log of bytes seen by the modelled slave are compared only after `done`, because these results settle at the final STOP. Per-edge SCL and SDA timing is measured on every falling clock edge against the low-phase and hold-delay counts, and the totals are checked once per transaction.

// File: rtl/i2c_regseq_pkg.sv
package i2c_regseq_pkg;

  typedef enum logic [1:0] {
    SYM_START = 2'd0,
    SYM_BIT   = 2'd1,
    SYM_STOP  = 2'd2
  } symKind_e;

  typedef enum logic [2:0] {
    SEL_IDW  = 3'd0,
    SEL_ADDR = 3'd1,
    SEL_DATA = 3'd2,
    SEL_IDR  = 3'd3,
    SEL_RX   = 3'd4
  } byteSel_e;

  typedef struct packed {
    logic     accept;    // request taken this cycle
    logic     go;        // start a new bus symbol this cycle
    symKind_e kind;      // kind of that symbol
    logic     load;      // reload the shift register
    byteSel_e sel;       // byte to reload with
    logic     ackSlot;   // current bit is the ninth slot of a byte
    logic     slaveAck;  // ninth slot is answered by the slave
    logic     capture;   // ninth slot ends a received byte
  } seqCtrl_t;

endpackage

// File: rtl/i2c_regseq_ctrl.sv
module i2c_regseq_ctrl
  import i2c_regseq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqRead,
  input  logic     symDone,
  output seqCtrl_t ctl,
  output logic     busy,
  output logic     done
);

  typedef enum logic {ST_IDLE, ST_RUN} state_e;

  localparam int STEP_W = 3;
  localparam int BIT_W  = 4;
  localparam logic [BIT_W-1:0] ACK_BIT = BIT_W'(8);

  state_e            state;
  logic [STEP_W-1:0] step, nxtStep;
  logic [BIT_W-1:0]  bitIdx, nxtBit;
  logic              isRead;
  logic              finish;
  symKind_e          curKind, nxtKind;
  logic              rxStep;

  // Write: START, IDW, ADDR, DATA, STOP.
  // Read : START, IDW, ADDR, STOP, START, IDR, RX, STOP.
  function automatic symKind_e stepKind(input logic rd, input logic [STEP_W-1:0] s);
    if (s == 3'd0) return SYM_START;
    if (rd) begin
      if (s == 3'd4) return SYM_START;
      if (s == 3'd3 || s == 3'd7) return SYM_STOP;
      return SYM_BIT;
    end
    if (s == 3'd4) return SYM_STOP;
    return SYM_BIT;
  endfunction

  function automatic byteSel_e stepSel(input logic rd, input logic [STEP_W-1:0] s);
    case (s)
      3'd1:    return SEL_IDW;
      3'd2:    return SEL_ADDR;
      3'd3:    return rd ? SEL_IDW : SEL_DATA;
      3'd5:    return SEL_IDR;
      3'd6:    return SEL_RX;
      default: return SEL_IDW;
    endcase
  endfunction

  logic [STEP_W-1:0] lastStep;
  assign lastStep = isRead ? 3'd7 : 3'd4;
  assign curKind  = stepKind(isRead, step);
  assign rxStep   = isRead && (step == 3'd6);

  always_comb begin
    ctl      = '0;
    ctl.kind = SYM_START;
    ctl.sel  = SEL_IDW;
    nxtStep  = step;
    nxtBit   = bitIdx;
    nxtKind  = SYM_START;
    finish   = 1'b0;
    ctl.ackSlot  = (state == ST_RUN) && (curKind == SYM_BIT) && (bitIdx == ACK_BIT);
    ctl.slaveAck = ctl.ackSlot && !rxStep;
    ctl.capture  = ctl.ackSlot && rxStep;
    if (state == ST_IDLE) begin
      if (reqValid) begin
        ctl.accept = 1'b1;
        ctl.go     = 1'b1;
        ctl.kind   = SYM_START;
        nxtStep    = '0;
        nxtBit     = '0;
      end
    end else if (symDone) begin
      if (curKind == SYM_BIT && bitIdx != ACK_BIT) begin
        nxtBit   = bitIdx + 1'b1;
        ctl.go   = 1'b1;
        ctl.kind = SYM_BIT;
      end else if (step == lastStep) begin
        finish = 1'b1;
      end else begin
        nxtStep  = step + 1'b1;
        nxtBit   = '0;
        nxtKind  = stepKind(isRead, nxtStep);
        ctl.go   = 1'b1;
        ctl.kind = nxtKind;
        ctl.load = (nxtKind == SYM_BIT);
        ctl.sel  = stepSel(isRead, nxtStep);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      step   <= '0;
      bitIdx <= '0;
      isRead <= 1'b0;
      done   <= 1'b0;
    end else begin
      step   <= nxtStep;
      bitIdx <= nxtBit;
      done   <= finish;
      if (ctl.accept) begin
        isRead <= reqRead;
        state  <= ST_RUN;
      end else if (finish) begin
        state <= ST_IDLE;
      end
    end
  end

  assign busy = (state == ST_RUN);

  // R5: the completion strobe lasts a single cycle
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5: busy only ends together with the completion strobe
  assert_busy_end_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R8: a request arriving mid-transaction does not restart the sequence
  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && reqValid && !symDone) |=> (step == $past(step)));

endmodule

// File: rtl/i2c_regseq_dp.sv
module i2c_regseq_dp
  import i2c_regseq_pkg::*;
#(
  parameter int         SCL_PERIOD = 20,
  parameter int         SDA_HOLD   = 4,
  parameter logic [7:0] DEV_ID     = 8'h40
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqCtrl_t   ctl,
  input  logic [7:0] reqAddr,
  input  logic [7:0] reqData,
  input  logic       sdaIn,
  output logic       symDone,
  output logic       sclLow,
  output logic       sdaLow,
  output logic [7:0] rdData,
  output logic       ackErr
);

  localparam int HALF     = SCL_PERIOD / 2;
  localparam int HOLD_EFF = (SDA_HOLD < HALF) ? SDA_HOLD : HALF - 1;
  localparam int STOP_LEN = SCL_PERIOD + HALF;
  localparam int CW       = $clog2(STOP_LEN + 1);

  localparam logic [CW-1:0] C_HALF   = CW'(HALF);
  localparam logic [CW-1:0] C_HOLD   = CW'(HOLD_EFF);
  localparam logic [CW-1:0] C_PER    = CW'(SCL_PERIOD);
  localparam logic [CW-1:0] C_BITEND = CW'(SCL_PERIOD - 1);
  localparam logic [CW-1:0] C_STPEND = CW'(STOP_LEN - 1);

  localparam logic [7:0] ID_WR = {DEV_ID[7:1], 1'b0};
  localparam logic [7:0] ID_RD = {DEV_ID[7:1], 1'b1};

  logic [CW-1:0] cnt, lastCnt;
  logic          active;
  symKind_e      kindQ;
  logic [7:0]    addrQ, dataQ, shiftReg, loadVal;
  logic          txLevel;

  assign lastCnt = (kindQ == SYM_STOP) ? C_STPEND : C_BITEND;
  assign symDone = active && (cnt == lastCnt);
  assign txLevel = ctl.ackSlot ? 1'b1 : shiftReg[7];

  always_comb begin
    case (ctl.sel)
      SEL_IDW:  loadVal = ID_WR;
      SEL_ADDR: loadVal = addrQ;
      SEL_DATA: loadVal = dataQ;
      SEL_IDR:  loadVal = ID_RD;
      default:  loadVal = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      active   <= 1'b0;
      kindQ    <= SYM_START;
      addrQ    <= '0;
      dataQ    <= '0;
      shiftReg <= '0;
      rdData   <= '0;
      ackErr   <= 1'b0;
      sclLow   <= 1'b0;
      sdaLow   <= 1'b0;
    end else begin
      if (ctl.accept) begin
        addrQ  <= reqAddr;
        dataQ  <= reqData;
        ackErr <= 1'b0;
      end
      if (active) begin
        cnt <= cnt + 1'b1;
        case (kindQ)
          SYM_START: begin
            sclLow <= 1'b0;
            if (cnt == C_HALF) sdaLow <= 1'b1;
          end
          SYM_BIT: begin
            if (cnt == '0)     sclLow <= 1'b1;
            if (cnt == C_HALF) sclLow <= 1'b0;
            if (cnt == C_HOLD) sdaLow <= !txLevel;
          end
          default: begin
            if (cnt == '0)     sclLow <= 1'b1;
            if (cnt == C_HALF) sclLow <= 1'b0;
            if (cnt == C_HOLD) sdaLow <= 1'b1;
            if (cnt == C_PER)  sdaLow <= 1'b0;
          end
        endcase
      end
      if (symDone && kindQ == SYM_BIT) begin
        if (ctl.slaveAck) begin
          if (sdaIn) ackErr <= 1'b1;
        end else if (ctl.capture) begin
          rdData <= shiftReg;
        end else begin
          shiftReg <= {shiftReg[6:0], sdaIn};
        end
      end
      if (symDone) active <= 1'b0;
      if (ctl.go) begin
        active <= 1'b1;
        cnt    <= '0;
        kindQ  <= ctl.kind;
      end
      if (ctl.load) shiftReg <= loadVal;
    end
  end

  // R7: inside a data or acknowledge bit SDA holds while SCL is high
  assert_sda_steady_R7: assert property (@(posedge clk) disable iff (!rstN)
    (active && kindQ == SYM_BIT && !sclLow && !$past(sclLow) && cnt != '0) |-> $stable(sdaLow));

  // R7: SDA never moves on the same edge at which SCL is pulled low
  generate
    if (HOLD_EFF > 0) begin : g_holdChk
      assert_sda_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
        $rose(sclLow) |-> $stable(sdaLow));
    end
  endgenerate

  // R4: the error flag stays set until a new request is accepted
  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ackErr && !ctl.accept) |=> ackErr);

endmodule

// File: rtl/i2c_regseq.sv
module i2c_regseq
  import i2c_regseq_pkg::*;
#(
  parameter int         SCL_PERIOD = 20,
  parameter int         SDA_HOLD   = 4,
  parameter logic [7:0] DEV_ID     = 8'h40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqRead,
  input  logic [7:0] reqAddr,
  input  logic [7:0] reqData,
  input  logic       sdaIn,
  output logic       sclDriveLow,
  output logic       sdaDriveLow,
  output logic       busy,
  output logic       done,
  output logic [7:0] rdData,
  output logic       ackErr
);

  seqCtrl_t ctl;
  logic     symDone;

  i2c_regseq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqRead  (reqRead),
    .symDone  (symDone),
    .ctl      (ctl),
    .busy     (busy),
    .done     (done)
  );

  i2c_regseq_dp #(
    .SCL_PERIOD (SCL_PERIOD),
    .SDA_HOLD   (SDA_HOLD),
    .DEV_ID     (DEV_ID)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .reqAddr (reqAddr),
    .reqData (reqData),
    .sdaIn   (sdaIn),
    .symDone (symDone),
    .sclLow  (sclDriveLow),
    .sdaLow  (sdaDriveLow),
    .rdData  (rdData),
    .ackErr  (ackErr)
  );

  // R5: both lines are released whenever no transaction runs
  assert_idle_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclDriveLow && !sdaDriveLow));

endmodule

// File: tb/i2c_regseq_tb.sv
module i2c_regseq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int P    = 20;
  localparam int HOLD = 4;
  localparam int H    = P / 2;
  localparam logic [7:0] ID = 8'h40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqRead = 1'b0;
  logic [7:0] reqAddr = '0, reqData = '0;
  logic sclLow, sdaLowM, busy, done, ackErr;
  logic [7:0] rdData;
  logic slaveLow = 1'b0;
  logic sdaLine;

  assign sdaLine = !(sdaLowM || slaveLow);

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_regseq #(.SCL_PERIOD(P), .SDA_HOLD(HOLD), .DEV_ID(ID)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRead(reqRead),
    .reqAddr(reqAddr), .reqData(reqData), .sdaIn(sdaLine),
    .sclDriveLow(sclLow), .sdaDriveLow(sdaLowM), .busy(busy), .done(done),
    .rdData(rdData), .ackErr(ackErr)
  );

  int tests = 0, fails = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- slave model and bus monitor ----------------
  logic [7:0] logBytes [0:255];
  int logCount = 0, startCount = 0, stopCount = 0;
  int nackPos = -1;
  logic [7:0] rdVal = 8'h00;
  logic masterAck = 1'b0;
  logic prevScl = 1'b1, prevSda = 1'b1, rdMode = 1'b0, afterStart = 1'b0;
  logic [7:0] rxShift = '0;
  int bitCnt = 0, byteInTxn = 0;
  int lowLen = 0, highLen = 1000, sinceFall = 1000;
  int lowErr = 0, highErr = 0, holdErr = 0;
  logic prevSclLow = 1'b0, prevSdaLowM = 1'b0;

  always @(negedge clk) begin
    logic scl, sda;
    scl = !sclLow;
    sda = sdaLine;
    if (!rstN) begin
      slaveLow = 1'b0; bitCnt = 0; byteInTxn = 0; rdMode = 1'b0;
    end else if (scl && prevScl && prevSda && !sda) begin
      startCount++; bitCnt = 0; byteInTxn = 0; rdMode = 1'b0;
      slaveLow = 1'b0; afterStart = 1'b1;
    end else if (scl && prevScl && !prevSda && sda) begin
      stopCount++; slaveLow = 1'b0;
    end else if (scl && !prevScl) begin
      if (bitCnt < 8) rxShift = {rxShift[6:0], sda};
      else masterAck = sda;
    end else if (!scl && prevScl) begin
      if (afterStart) begin
        afterStart = 1'b0;
      end else if (bitCnt < 7) begin
        bitCnt++;
        if (rdMode && byteInTxn == 1) slaveLow = !rdVal[7-bitCnt];
      end else if (bitCnt == 7) begin
        bitCnt = 8;
        if (rdMode && byteInTxn == 1) begin
          slaveLow = 1'b0;
        end else begin
          logBytes[logCount % 256] = rxShift;
          logCount++;
          if (byteInTxn == 0) rdMode = rxShift[0];
          slaveLow = !(byteInTxn == nackPos);
        end
      end else begin
        bitCnt = 0;
        byteInTxn++;
        slaveLow = (rdMode && byteInTxn == 1) ? !rdVal[7] : 1'b0;
      end
    end
    prevScl = !sclLow;
    prevSda = sdaLine;
    // timing monitor on the master's drive outputs (R6, R7)
    if (rstN) begin
      if (sclLow && !prevSclLow) begin
        if (highLen < P - H) highErr++;
        lowLen = 1; sinceFall = 0;
      end else if (!sclLow && prevSclLow) begin
        if (lowLen != H) lowErr++;
        highLen = 1; sinceFall++;
      end else begin
        lowLen++; highLen++; sinceFall++;
      end
      if (sdaLowM != prevSdaLowM && sclLow && sinceFall != HOLD) holdErr++;
    end
    prevSclLow = sclLow;
    prevSdaLowM = sdaLowM;
  end

  // ---------------- expected values ----------------
  function automatic int expLen(input bit rd);
    return rd ? (40*P + 2*H) : (29*P + H);
  endfunction

  function automatic bit expErr(input bit rd, input int np);
    return rd ? (np == 0 || np == 1) : (np >= 0 && np <= 2);
  endfunction

  task automatic runTxn(input bit rd, input logic [7:0] addr, input logic [7:0] data,
                        input logic [7:0] slaveByte, input int np, input int injectAt);
    int n, logBase, stBase, spBase, e0, e1, e2;
    logic [7:0] exp [0:2];
    nackPos = np;
    rdVal = slaveByte;
    logBase = logCount; stBase = startCount; spBase = stopCount;
    e0 = lowErr; e1 = highErr; e2 = holdErr;
    @(negedge clk);
    reqValid = 1'b1; reqRead = rd; reqAddr = addr; reqData = data;
    @(negedge clk);
    reqValid = 1'b0;
    check(busy == 1'b1, "R5 busy after accept", busy, 1);
    n = 0;
    while (!done && n < 5000) begin
      if (n == injectAt) begin
        reqValid = 1'b1; reqRead = !rd; reqAddr = ~addr; reqData = ~data;
      end else begin
        reqValid = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    reqValid = 1'b0;
    check(n == expLen(rd), rd ? "R5 read latency" : "R5 write latency", n, expLen(rd));
    check(busy == 1'b0, "R5 busy low with done", busy, 0);
    @(negedge clk);
    check(done == 1'b0 && !sclLow && !sdaLowM, "R5 single done, lines released",
          {done, sclLow, sdaLowM}, 0);
    exp[0] = {ID[7:1], 1'b0};
    exp[1] = addr;
    exp[2] = rd ? {ID[7:1], 1'b1} : data;
    check(logCount - logBase == 3, "R8 byte count on bus", logCount - logBase, 3);
    for (int i = 0; i < 3; i++)
      check(logBytes[(logBase + i) % 256] == exp[i], rd ? "R2 read byte" : "R1 write byte",
            logBytes[(logBase + i) % 256], exp[i]);
    check(startCount - stBase == (rd ? 2 : 1), rd ? "R2 START count" : "R1 START count",
          startCount - stBase, rd ? 2 : 1);
    check(stopCount - spBase == (rd ? 2 : 1), "R4 STOP count (R1/R2)",
          stopCount - spBase, rd ? 2 : 1);
    check(ackErr == expErr(rd, np), "R4 ack error flag", ackErr, expErr(rd, np));
    if (rd) begin
      check(rdData == slaveByte, "R3 read data", rdData, slaveByte);
      check(masterAck == 1'b1, "R2 master NACK", masterAck, 1);
    end
    check(lowErr == e0 && highErr == e1, "R6 SCL phase lengths", lowErr + highErr - e0 - e1, 0);
    check(holdErr == e2, "R7 SDA hold delay", holdErr - e2, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!busy && !done && !ackErr && rdData == 8'h00 && !sclLow && !sdaLowM,
          "R9 reset state", {busy, done, ackErr, rdData, sclLow, sdaLowM}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // directed corner cases
    runTxn(1'b0, 8'h3A, 8'h72, 8'h00, -1, -1);   // R1
    runTxn(1'b0, 8'h00, 8'hFF, 8'h00, -1, -1);   // R1 extremes
    runTxn(1'b1, 8'hFF, 8'h00, 8'hA5, -1, -1);   // R2 R3
    runTxn(1'b1, 8'h01, 8'h00, 8'h00, -1, -1);   // R3 all-zero data
    runTxn(1'b1, 8'h80, 8'h00, 8'hFF, -1, -1);   // R3 all-one data
    runTxn(1'b0, 8'h12, 8'h34, 8'h00, 0, -1);    // R4 nack on ID
    runTxn(1'b0, 8'h12, 8'h34, 8'h00, 2, -1);    // R4 nack on data
    runTxn(1'b0, 8'h12, 8'h34, 8'h00, -1, -1);   // R4 cleared by next request
    runTxn(1'b1, 8'h55, 8'h00, 8'h3C, 1, -1);    // R4 nack on register address in read
    runTxn(1'b0, 8'h21, 8'h43, 8'h00, -1, 100);  // R8 request while busy ignored
    runTxn(1'b1, 8'h65, 8'h00, 8'h87, -1, 400);  // R8 during read
    // constrained random
    for (int k = 0; k < 24; k++) begin
      bit rd;
      int np;
      rd = $urandom_range(0, 1);
      np = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 2) : -1;
      runTxn(rd, 8'($urandom), 8'($urandom), 8'($urandom), np,
             ($urandom_range(0, 3) == 0) ? $urandom_range(1, 500) : -1);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule